// File: doc/BRIEF.md
# Serial Delta-RGB Pixel Serializer

This block drives a panel that has an 8-bit data bus while the pixels are 24 bits wide. It takes one pixel at a time through a valid/ready handshake and puts it on the bus as three bytes, one colour component per byte, on three successive dot-clock ticks. The dot clock is a fixed fraction of the system clock. An enable strobe marks the first system cycle of each new byte.

The order of the three components can differ between odd and even lines. This supports panels whose subpixels are staggered from one line to the next. A single configuration byte holds one order field for odd lines and one for even lines. Each field selects any of the six permutations. A new configuration byte is held in a shadow register and is loaded at the next start-of-frame, so the order never changes in the middle of a frame.

Lines are counted from 1 at each start-of-frame. Start-of-line markers on the incoming stream switch between odd and even. When no pixel is waiting at a pixel boundary, the bus stays idle for one whole pixel slot.

Top module: `delta_rgb_serializer`

## Requirements
- R1: A pixel carries red in bits [23:16], green in [15:8] and blue in [7:0]. The three components leave on three consecutive dot ticks, with `lcd_de` high for each of the three bytes.
- R2: An order code gives the component sequence as follows: 0 = R,G,B; 1 = R,B,G; 2 = G,R,B; 3 = G,B,R; 4 = B,R,G; 5 = B,G,R.
- R3: Odd lines use the code in configuration bits [6:4] and even lines use the code in bits [2:0]. After reset the value is 0x03, which gives R,G,B on odd lines and G,B,R on even lines.
- R4: A pixel marked start-of-frame begins line 1, which is odd. A start-of-line marker without start-of-frame flips the parity. After reset, before any start-of-frame, the first start-of-line begins an odd line.
- R5: Codes 6 and 7 produce the R,G,B sequence.
- R6: A configuration write takes effect with the next accepted pixel that carries start-of-frame, and that pixel uses the new value. Pixels without start-of-frame keep the previous orders. A write in the same cycle as the acceptance of a start-of-frame pixel applies only from the frame after it.
- R7: A configuration value of 0 gives R,G,B on both parities.
- R8: `pix_ready` is high for exactly one system cycle every third dot tick, whatever `pix_valid` is. That cycle closes the last byte slot of a pixel, and the following cycle has `lcd_dot_en` high.
- R9: When `pix_valid` is low in a `pix_ready` cycle, the next three byte slots have `lcd_de` low and `lcd_data` equal to zero.
- R10: `lcd_dot_en` is high for one system cycle out of every `DOT_DIV`. `lcd_data` and `lcd_de` change only on the edge that raises `lcd_dot_en`.
- R11: While reset is held, `lcd_data` is zero and `lcd_de`, `lcd_dot_en` and `pix_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the order configuration |
| cfg_wdata | input | 8 | Configuration byte: odd-line code [6:4], even-line code [2:0] |
| pix_valid | input | 1 | Pixel on `pix_data` is valid |
| pix_data | input | 3*COMP_W | Pixel, red in the top component |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_ready | output | 1 | Pixel is taken at this clock edge if valid |
| lcd_data | output | COMP_W | Serial component byte |
| lcd_de | output | 1 | Byte on `lcd_data` is valid |
| lcd_dot_en | output | 1 | First system cycle of a new byte slot |

## Verification
Two events can happen on the same clock edge: a start-of-frame pixel is accepted, which loads the shadow orders, and software writes a new configuration byte. The bench raises `cfg_we` in exactly the cycle that `pix_ready` is high for a start-of-frame pixel. That pixel and its frame must keep the value written before, and the next frame must use the new value. A behavioural model holds the old and new register contents separately and compares every byte on every clock. Parity flips and start-of-frame markers are also mixed across frames in which the code changes.

// File: rtl/drs_pkg.sv
package drs_pkg;

  localparam int unsigned NCOMP = 3;
  localparam logic [7:0] CFG_RESET = 8'h03;

  typedef enum logic [2:0] {
    ORD_RGB = 3'd0,
    ORD_RBG = 3'd1,
    ORD_GRB = 3'd2,
    ORD_GBR = 3'd3,
    ORD_BRG = 3'd4,
    ORD_BGR = 3'd5
  } chan_order_e;

  // Reserved codes fold onto the plain order.
  function automatic logic [2:0] fold_code(input logic [2:0] code);
    return (code > 3'd5) ? 3'(ORD_RGB) : code;
  endfunction

  // Component index (0 red, 1 green, 2 blue) sent in a given byte slot.
  function automatic logic [1:0] comp_of(input logic [2:0] code,
                                         input logic [1:0] slot);
    logic [5:0] seq;
    case (code)
      3'(ORD_RBG): seq = 6'b00_10_01;
      3'(ORD_GRB): seq = 6'b01_00_10;
      3'(ORD_GBR): seq = 6'b01_10_00;
      3'(ORD_BRG): seq = 6'b10_00_01;
      3'(ORD_BGR): seq = 6'b10_01_00;
      default:     seq = 6'b00_01_10;
    endcase
    case (slot)
      2'd0:    return seq[5:4];
      2'd1:    return seq[3:2];
      default: return seq[1:0];
    endcase
  endfunction

endpackage

// File: rtl/drs_dot_tick.sv
module drs_dot_tick #(
  parameter int unsigned DOT_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic dot_en
);

  generate
    if (DOT_DIV <= 1) begin : g_full_rate
      assign tick = 1'b1;
    end else begin : g_divided
      localparam int unsigned CW = $clog2(DOT_DIV);
      localparam logic [CW-1:0] LAST = CW'(DOT_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dot_en <= 1'b0;
    else     dot_en <= tick;
  end

endmodule

// File: rtl/drs_order_ctl.sv
module drs_order_ctl
  import drs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       accept,
  input  logic       sol,
  input  logic       sof,
  output logic [2:0] ord_code
);

  logic [2:0] shadow_odd, shadow_even;
  logic [2:0] live_odd, live_even;
  logic       line_odd;
  logic       eff_odd;
  logic [2:0] src_odd, src_even;
  logic       unused_cfg_bits;

  assign unused_cfg_bits = cfg_wdata[7] ^ cfg_wdata[3];

  // Parity and orders that the pixel being offered would use.
  assign eff_odd  = sof ? 1'b1 : (sol ? ~line_odd : line_odd);
  assign src_odd  = sof ? shadow_odd  : live_odd;
  assign src_even = sof ? shadow_even : live_even;
  assign ord_code = fold_code(eff_odd ? src_odd : src_even);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_odd  <= CFG_RESET[6:4];
      shadow_even <= CFG_RESET[2:0];
      live_odd    <= CFG_RESET[6:4];
      live_even   <= CFG_RESET[2:0];
      line_odd    <= 1'b0;
    end else begin
      if (cfg_we) begin
        shadow_odd  <= cfg_wdata[6:4];
        shadow_even <= cfg_wdata[2:0];
      end
      if (accept) begin
        line_odd <= eff_odd;
        if (sof) begin
          live_odd  <= shadow_odd;
          live_even <= shadow_even;
        end
      end
    end
  end

endmodule

// File: rtl/drs_byte_out.sv
module drs_byte_out
  import drs_pkg::*;
#(
  parameter int unsigned COMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     pix_valid,
  input  logic [NCOMP*COMP_W-1:0]  pix_data,
  input  logic [2:0]               ord_code,
  output logic                     ready,
  output logic [COMP_W-1:0]        data_o,
  output logic                     de_o
);

  localparam int unsigned PW = NCOMP * COMP_W;

  logic [1:0]    slot;
  logic          active;
  logic [PW-1:0] pix_q;
  logic [2:0]    ord_q;
  logic [1:0]    nxt_slot;

  function automatic logic [COMP_W-1:0] pick(input logic [PW-1:0] px,
                                             input logic [2:0] code,
                                             input logic [1:0] s);
    case (comp_of(code, s))
      2'd0:    return px[PW-1 -: COMP_W];
      2'd1:    return px[2*COMP_W-1 -: COMP_W];
      default: return px[COMP_W-1:0];
    endcase
  endfunction

  assign ready    = tick && (slot == 2'd2);
  assign nxt_slot = slot + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= 2'd2;
      active <= 1'b0;
      pix_q  <= '0;
      ord_q  <= '0;
      data_o <= '0;
      de_o   <= 1'b0;
    end else if (tick) begin
      if (slot == 2'd2) begin
        slot <= 2'd0;
        if (pix_valid) begin
          pix_q  <= pix_data;
          ord_q  <= ord_code;
          active <= 1'b1;
          data_o <= pick(pix_data, ord_code, 2'd0);
          de_o   <= 1'b1;
        end else begin
          active <= 1'b0;
          data_o <= '0;
          de_o   <= 1'b0;
        end
      end else begin
        slot <= nxt_slot;
        if (active) begin
          data_o <= pick(pix_q, ord_q, nxt_slot);
          de_o   <= 1'b1;
        end else begin
          data_o <= '0;
          de_o   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/delta_rgb_serializer.sv
module delta_rgb_serializer
  import drs_pkg::*;
#(
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned DOT_DIV = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_wdata,
  input  logic                    pix_valid,
  input  logic [NCOMP*COMP_W-1:0] pix_data,
  input  logic                    pix_sol,
  input  logic                    pix_sof,
  output logic                    pix_ready,
  output logic [COMP_W-1:0]       lcd_data,
  output logic                    lcd_de,
  output logic                    lcd_dot_en
);

  logic       tick;
  logic       accept;
  logic [2:0] ord_code;

  assign accept = pix_ready && pix_valid;

  drs_dot_tick #(.DOT_DIV(DOT_DIV)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .dot_en (lcd_dot_en)
  );

  drs_order_ctl order_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .accept    (accept),
    .sol       (pix_sol),
    .sof       (pix_sof),
    .ord_code  (ord_code)
  );

  drs_byte_out #(.COMP_W(COMP_W)) bytes_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .ord_code  (ord_code),
    .ready     (pix_ready),
    .data_o    (lcd_data),
    .de_o      (lcd_de)
  );

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned DOT_DIV = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_ready,
  input logic [COMP_W-1:0] lcd_data,
  input logic              lcd_de,
  input logic              lcd_dot_en
);

  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_QUIET: assert (!lcd_de && lcd_data == '0 && !lcd_dot_en); // R11
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lcd_de |-> lcd_data == '0); // R9

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !lcd_dot_en |-> ($stable(lcd_data) && $stable(lcd_de))); // R10

  AST_DOT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (lcd_dot_en && DOT_DIV > 1) |=> !lcd_dot_en); // R10

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> !pix_ready); // R8

  AST_READY_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> lcd_dot_en); // R8

endmodule

bind delta_rgb_serializer drs_checker #(.COMP_W(COMP_W), .DOT_DIV(DOT_DIV)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pix_ready  (pix_ready),
  .lcd_data   (lcd_data),
  .lcd_de     (lcd_de),
  .lcd_dot_en (lcd_dot_en)
);

// File: tb/delta_rgb_serializer_tb_top.sv
module delta_rgb_serializer_tb_top;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = 24'h0;
  logic        pix_sol = 1'b0;
  logic        pix_sof = 1'b0;
  logic        pix_ready;
  logic [7:0]  lcd_data;
  logic        lcd_de;
  logic        lcd_dot_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  delta_rgb_serializer #(.COMP_W(8), .DOT_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .pix_ready(pix_ready), .lcd_data(lcd_data),
    .lcd_de(lcd_de), .lcd_dot_en(lcd_dot_en)
  );

  // ---------------- behavioural reference ----------------
  int perm [0:5][0:2] = '{'{0,1,2}, '{0,2,1}, '{1,0,2},
                          '{1,2,0}, '{2,0,1}, '{2,1,0}};
  int         m_cnt, m_ticks;
  logic [7:0] m_cfg;
  int         m_aodd, m_aeven;
  bit         m_lodd;
  logic [7:0] q[$];
  logic [7:0] e_data;
  bit         e_de, e_dot;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ticks = 0; m_cfg = 8'h03;
      m_aodd = 0; m_aeven = 3; m_lodd = 0;
      q.delete(); e_data = 0; e_de = 0; e_dot = 0;
    end else begin
      bit tk;
      tk = ((m_cnt % DIV) == DIV - 1);
      m_cnt++;
      e_dot = tk;
      if (tk) begin
        if ((m_ticks % 3) == 0 && pix_valid) begin
          int code;
          if (pix_sof) begin
            m_lodd = 1; m_aodd = int'(m_cfg[6:4]); m_aeven = int'(m_cfg[2:0]);
          end else if (pix_sol) m_lodd = !m_lodd;
          code = m_lodd ? m_aodd : m_aeven;
          if (code > 5) code = 0;
          for (int k = 0; k < 3; k++)
            q.push_back(8'(pix_data >> (8 * (2 - perm[code][k]))));
        end
        m_ticks++;
        if (q.size() > 0) begin e_data = q.pop_front(); e_de = 1; end
        else begin e_data = 0; e_de = 0; end
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", what, cur_tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      bit e_rdy;
      e_rdy = ((m_cnt % DIV) == DIV - 1) && ((m_ticks % 3) == 0);
      check(lcd_data == e_data, "R1 data", int'(lcd_data), int'(e_data));
      check(lcd_de == e_de, "R1 de", int'(lcd_de), int'(e_de));
      check(lcd_dot_en == e_dot, "R10 dot_en", int'(lcd_dot_en), int'(e_dot));
      check(pix_ready == e_rdy, "R8 ready", int'(pix_ready), int'(e_rdy));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(logic [23:0] px, bit sol, bit sof, bit wr, logic [7:0] wv);
    pix_valid = 1; pix_data = px; pix_sol = sol; pix_sof = sof;
    while (!pix_ready) @(negedge clk);
    if (wr) begin cfg_we = 1; cfg_wdata = wv; end
    @(negedge clk);
    cfg_we = 0; pix_valid = 0; pix_sol = 0; pix_sof = 0;
  endtask

  task automatic line(int n, bit sof, int gap, int seed);
    for (int i = 0; i < n; i++) begin
      send({8'(8'h10 + seed + i), 8'(8'h80 + seed + i), 8'(8'hE0 + seed + i)},
           i == 0, sof && i == 0, 0, 8'h00);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic frame(int lines, int n, int seed);
    for (int l = 0; l < lines; l++) line(n, l == 0, 0, seed + 4 * l);
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    cur_tag = "R11";
    check(lcd_data == 0 && !lcd_de, "R11 reset bus", int'({lcd_de, lcd_data}), 0);
    check(!lcd_dot_en && !pix_ready, "R11 reset strobes",
          int'({lcd_dot_en, pix_ready}), 0);
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    live = 1;

    cur_tag = "R1 R2 R3 R4 default orders";
    frame(3, 4, 0);

    cur_tag = "R6 write mid-frame, no effect yet";
    write_cfg(8'h15);
    line(3, 0, 0, 8'h20);
    line(3, 0, 0, 8'h28);

    cur_tag = "R2 R6 new orders from next frame";
    frame(3, 3, 8'h30);

    cur_tag = "R2 R3 codes 4 and 2";
    write_cfg(8'h42);
    frame(2, 3, 8'h40);

    cur_tag = "R6 write in same cycle as sof acceptance";
    write_cfg(8'h50);
    send(24'hA1B2C3, 1, 1, 1, 8'h24);
    line(2, 0, 0, 8'h48);
    line(2, 0, 0, 8'h4C);
    frame(2, 2, 8'h50);

    cur_tag = "R5 reserved codes";
    write_cfg(8'h67);
    frame(2, 3, 8'h60);

    cur_tag = "R7 zero value";
    write_cfg(8'h00);
    frame(3, 3, 8'h70);

    cur_tag = "R8 R9 gaps in the stream";
    write_cfg(8'h03);
    frame(1, 1, 8'h78);
    line(4, 0, 5, 8'h80);
    repeat (20) @(negedge clk);
    line(3, 0, 13, 8'h88);

    cur_tag = "R4 parity after reset without sof";
    do_reset();
    cur_tag = "R4 parity after reset without sof";
    line(2, 0, 0, 8'h90);
    line(2, 0, 0, 8'h94);
    line(2, 0, 0, 8'h98);
    send(24'h123456, 0, 1, 0, 8'h00);
    send(24'h654321, 0, 0, 0, 8'h00);

    repeat (12) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", cur_tag);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule